// File: doc/BRIEF.md
# Masked Interrupt Status Unit

This block keeps the interrupt status byte of a packet-buffer Ethernet controller, along with a mask byte, and produces one level-sensitive interrupt line. There are two kinds of status bits. Some are driven by queue state: "transmit queue empty" and "transmit-done queue holds entries". These bits are raised again every cycle their condition holds, so an acknowledge clears them only once the queue has moved on. The others are event bits: allocation done, frame received, receive overrun and two auxiliary events. Software clears these with a write-one-to-clear acknowledge, but only for bits inside a fixed protection mask.

The queues live outside this block. They report their state and events through single-bit inputs. Writing an acknowledge with the transmit bit set sends a one-cycle pop strobe back to the transmit-done queue. Software reads the live status byte and the mask byte directly from the outputs.

Top module: `int_status_unit`

## Requirements
- R1: After reset the status byte is 0x04, the mask byte is 0x00, `irq_o` is low and `txdone_pop_o` is low.
- R2: Bit 2 (transmit queue empty) is set in the cycle after any cycle with `tx_q_empty_i` high. An acknowledge clears it only when `tx_q_empty_i` is low in that same cycle.
- R3: Bit 1 (transmit done) is set in the cycle after any cycle with `txdone_q_nonempty_i` high. An acknowledge clears it only when that input is low in the same cycle.
- R4: An acknowledge write (`wr_en_i`=1, `wr_addr_i`=0) clears only the status bits selected by `wr_data_i & 0xD6`. Bits 0, 3 and 5 are never changed by an acknowledge.
- R5: Bit 3 (allocation) is set by `alloc_done_i` and cleared by `alloc_req_i`. If both are high in the same cycle, the set takes priority.
- R6: Bit 0 (frame received) is set by `rx_land_i`. `rx_pop_i` loads it with `rx_q_more_i`, which means it stays set while entries remain and clears when the queue is empty. `rx_land_i` takes priority over a pop in the same cycle.
- R7: Bits 4 (`rx_ovrn_i`), 6 (`aux_evt_i[0]`) and 7 (`aux_evt_i[1]`) are sticky until acknowledged. A set and an acknowledge in the same cycle leave the bit set.
- R8: `irq_o` is high exactly when some bit is set in both `status_o` and `mask_o`.
- R9: A mask write (`wr_en_i`=1, `wr_addr_i`=1) loads `mask_o` on the next cycle. The mask holds its value at all other times.
- R10: `txdone_pop_o` is high for one cycle, in the cycle after an acknowledge write with `wr_data_i[1]`=1, whatever the value of the status bits. It is low at all other times.
- R11: Bit 5 of the status byte always reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 1 | Write target: 0 selects acknowledge, 1 selects mask |
| wr_data_i | input | 8 | Write data |
| tx_q_empty_i | input | 1 | Transmit queue is empty |
| txdone_q_nonempty_i | input | 1 | Transmit-done queue holds entries |
| alloc_req_i | input | 1 | New allocation requested; clears bit 3 |
| alloc_done_i | input | 1 | Allocation succeeded; sets bit 3 |
| rx_ovrn_i | input | 1 | Receive overrun event |
| rx_land_i | input | 1 | Frame placed in the receive queue |
| rx_pop_i | input | 1 | Receive queue head removed |
| rx_q_more_i | input | 1 | Receive queue still non-empty after the pop |
| aux_evt_i | input | 2 | Auxiliary events for bits 6 and 7 |
| status_o | output | 8 | Live status byte |
| mask_o | output | 8 | Mask byte |
| irq_o | output | 1 | Interrupt level |
| txdone_pop_o | output | 1 | One-cycle pop strobe to the transmit-done queue |

## Verification
Any status bit with the wrong value appears on `status_o` one cycle after the input that caused it. If that bit is also masked in, the same error shows on `irq_o` in the same cycle. A protection mask that lets the wrong bits through shows up as bit 0 or bit 3 dropping right after an acknowledge. A fault in the pop path shows as a missing or extra `txdone_pop_o` pulse in the cycle after the write. The bench runs a per-cycle reference of the status byte, so the first cycle that differs is reported.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int unsigned STAT_W = 8;

  localparam int unsigned BIT_RCV   = 0;
  localparam int unsigned BIT_TX    = 1;
  localparam int unsigned BIT_TXEMP = 2;
  localparam int unsigned BIT_ALLOC = 3;
  localparam int unsigned BIT_OVRN  = 4;
  localparam int unsigned BIT_RSVD  = 5;
  localparam int unsigned BIT_AUX0  = 6;
  localparam int unsigned BIT_AUX1  = 7;

  localparam logic [STAT_W-1:0] RESET_STATUS = 8'h04;

  typedef struct packed {
    logic tx_empty;
    logic txdone_nonempty;
    logic alloc_req;
    logic alloc_done;
    logic rx_ovrn;
    logic rx_land;
    logic rx_pop;
    logic rx_more;
    logic [1:0] aux;
  } irq_src_t;
endpackage

// File: rtl/irq_wr_decode.sv
module irq_wr_decode
  import irq_pkg::*;
#(
  parameter logic [STAT_W-1:0] ACK_MASK = 8'hD6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              wr_addr_i,
  input  logic [STAT_W-1:0] wr_data_i,
  output logic [STAT_W-1:0] ack_clr_o,
  output logic              mask_we_o,
  output logic              pop_o
);
  logic ack_we;
  logic pop_q;

  assign ack_we    = wr_en_i & ~wr_addr_i;
  assign mask_we_o = wr_en_i & wr_addr_i;
  // protected bits never reach the clear vector
  assign ack_clr_o = ack_we ? (wr_data_i & ACK_MASK) : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pop_q <= 1'b0;
    else         pop_q <= ack_we & wr_data_i[BIT_TX];
  end

  assign pop_o = pop_q;
endmodule

// File: rtl/irq_mask_reg.sv
module irq_mask_reg
  import irq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [STAT_W-1:0] data_i,
  output logic [STAT_W-1:0] mask_o
);
  logic [STAT_W-1:0] mask_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   mask_q <= '0;
    else if (we_i) mask_q <= data_i;
  end

  assign mask_o = mask_q;
endmodule

// File: rtl/irq_status_reg.sv
module irq_status_reg
  import irq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [STAT_W-1:0] ack_clr_i,
  input  irq_src_t          src_i,
  output logic [STAT_W-1:0] status_o
);
  logic [STAT_W-1:0] status_q, status_d, set_vec;

  // bits raised this cycle: queue-derived levels and event pulses
  always_comb begin
    set_vec            = '0;
    set_vec[BIT_TXEMP] = src_i.tx_empty;
    set_vec[BIT_TX]    = src_i.txdone_nonempty;
    set_vec[BIT_OVRN]  = src_i.rx_ovrn;
    set_vec[BIT_AUX0]  = src_i.aux[0];
    set_vec[BIT_AUX1]  = src_i.aux[1];
  end

  always_comb begin
    status_d = (status_q & ~ack_clr_i) | set_vec;
    if (src_i.alloc_req)  status_d[BIT_ALLOC] = 1'b0;
    if (src_i.alloc_done) status_d[BIT_ALLOC] = 1'b1;
    if (src_i.rx_pop)     status_d[BIT_RCV]   = src_i.rx_more;
    if (src_i.rx_land)    status_d[BIT_RCV]   = 1'b1;
    status_d[BIT_RSVD] = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) status_q <= RESET_STATUS;
    else         status_q <= status_d;
  end

  assign status_o = status_q;
endmodule

// File: rtl/int_status_unit.sv
module int_status_unit
  import irq_pkg::*;
#(
  parameter logic [7:0] ACK_MASK = 8'hD6
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_en_i,
  input  logic       wr_addr_i,
  input  logic [7:0] wr_data_i,
  input  logic       tx_q_empty_i,
  input  logic       txdone_q_nonempty_i,
  input  logic       alloc_req_i,
  input  logic       alloc_done_i,
  input  logic       rx_ovrn_i,
  input  logic       rx_land_i,
  input  logic       rx_pop_i,
  input  logic       rx_q_more_i,
  input  logic [1:0] aux_evt_i,
  output logic [7:0] status_o,
  output logic [7:0] mask_o,
  output logic       irq_o,
  output logic       txdone_pop_o
);
  logic [STAT_W-1:0] ack_clr;
  logic              mask_we;
  irq_src_t          src;

  assign src = '{tx_empty:        tx_q_empty_i,
                 txdone_nonempty: txdone_q_nonempty_i,
                 alloc_req:       alloc_req_i,
                 alloc_done:      alloc_done_i,
                 rx_ovrn:         rx_ovrn_i,
                 rx_land:         rx_land_i,
                 rx_pop:          rx_pop_i,
                 rx_more:         rx_q_more_i,
                 aux:             aux_evt_i};

  irq_wr_decode #(.ACK_MASK(ACK_MASK)) u_dec (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .wr_data_i (wr_data_i),
    .ack_clr_o (ack_clr),
    .mask_we_o (mask_we),
    .pop_o     (txdone_pop_o)
  );

  irq_mask_reg u_mask (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (mask_we),
    .data_i (wr_data_i),
    .mask_o (mask_o)
  );

  irq_status_reg u_stat (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ack_clr_i (ack_clr),
    .src_i     (src),
    .status_o  (status_o)
  );

  assign irq_o = |(status_o & mask_o);
endmodule

// File: rtl/int_status_unit_chk.sv
module int_status_unit_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       wr_en_i,
  input logic       wr_addr_i,
  input logic [7:0] wr_data_i,
  input logic       tx_q_empty_i,
  input logic       txdone_q_nonempty_i,
  input logic       alloc_req_i,
  input logic       alloc_done_i,
  input logic       rx_land_i,
  input logic [7:0] status_o,
  input logic [7:0] mask_o,
  input logic       txdone_pop_o
);
  // R2
  txemp_reassert_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_q_empty_i |=> status_o[2]);

  // R3
  txdone_reassert_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    txdone_q_nonempty_i |=> status_o[1]);

  // R4
  alloc_protected_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !wr_addr_i && !alloc_req_i && !alloc_done_i)
      |=> (status_o[3] == $past(status_o[3])));

  // R6
  rcv_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_land_i |=> status_o[0]);

  // R9
  mask_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_en_i && wr_addr_i) |=> $stable(mask_o));

  // R10
  pop_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !wr_addr_i && wr_data_i[1]) |=> txdone_pop_o);

  // R10
  pop_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_en_i && !wr_addr_i && wr_data_i[1]) |=> !txdone_pop_o);
endmodule

bind int_status_unit int_status_unit_chk u_chk (
  .clk_i               (clk_i),
  .rst_ni              (rst_ni),
  .wr_en_i             (wr_en_i),
  .wr_addr_i           (wr_addr_i),
  .wr_data_i           (wr_data_i),
  .tx_q_empty_i        (tx_q_empty_i),
  .txdone_q_nonempty_i (txdone_q_nonempty_i),
  .alloc_req_i         (alloc_req_i),
  .alloc_done_i        (alloc_done_i),
  .rx_land_i           (rx_land_i),
  .status_o            (status_o),
  .mask_o              (mask_o),
  .txdone_pop_o        (txdone_pop_o)
);

// File: tb/test_int_status_unit.sv
`timescale 1ns/1ps
module test_int_status_unit;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       wr_en_i = 1'b0, wr_addr_i = 1'b0;
  logic [7:0] wr_data_i = '0;
  logic       tx_q_empty_i = 1'b0, txdone_q_nonempty_i = 1'b0;
  logic       alloc_req_i = 1'b0, alloc_done_i = 1'b0, rx_ovrn_i = 1'b0;
  logic       rx_land_i = 1'b0, rx_pop_i = 1'b0, rx_q_more_i = 1'b0;
  logic [1:0] aux_evt_i = '0;
  logic [7:0] status_o, mask_o;
  logic       irq_o, txdone_pop_o;

  int checks = 0;
  int errors = 0;
  logic [7:0] exp_stat, exp_mask;
  logic       exp_pop;

  always #4 clk_i = ~clk_i;

  int_status_unit i_int_status_unit (.*);

  function automatic logic [7:0] next_stat(logic [7:0] q);
    logic [7:0] n;
    n = q;
    if (wr_en_i && !wr_addr_i) n = n & ~(wr_data_i & 8'hD6);
    if (tx_q_empty_i) n[2] = 1'b1;
    if (txdone_q_nonempty_i) n[1] = 1'b1;
    if (rx_ovrn_i) n[4] = 1'b1;
    if (aux_evt_i[0]) n[6] = 1'b1;
    if (aux_evt_i[1]) n[7] = 1'b1;
    if (alloc_req_i) n[3] = 1'b0;
    if (alloc_done_i) n[3] = 1'b1;
    if (rx_pop_i) n[0] = rx_q_more_i;
    if (rx_land_i) n[0] = 1'b1;
    n[5] = 1'b0;
    return n;
  endfunction

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic idle();
    wr_en_i = 0; wr_addr_i = 0; wr_data_i = 0;
    alloc_req_i = 0; alloc_done_i = 0; rx_ovrn_i = 0;
    rx_land_i = 0; rx_pop_i = 0; rx_q_more_i = 0; aux_evt_i = 0;
  endtask

  // advance one cycle, update model, compare all outputs
  task automatic tick();
    @(posedge clk_i);
    exp_stat = next_stat(exp_stat);
    if (wr_en_i && wr_addr_i) exp_mask = wr_data_i;
    exp_pop = wr_en_i && !wr_addr_i && wr_data_i[1];
    #2;
    chk("R2 R3 R4 R5 R6 R7 R11 status", status_o, exp_stat);
    chk("R9 mask", mask_o, exp_mask);
    chk("R8 irq", {7'd0, irq_o}, {7'd0, |(exp_stat & exp_mask)});
    chk("R10 pop", {7'd0, txdone_pop_o}, {7'd0, exp_pop});
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h1234_5678));
    #20;
    // R1 reset state
    chk("R1 status", status_o, 8'h04);
    chk("R1 mask", mask_o, 8'h00);
    chk("R1 irq", {7'd0, irq_o}, 8'h00);
    chk("R1 pop", {7'd0, txdone_pop_o}, 8'h00);
    exp_stat = 8'h04; exp_mask = 8'h00;
    @(negedge clk_i); rst_ni = 1'b1;
    @(negedge clk_i);

    // R2: ack of bit2 while queue empty keeps it set
    tx_q_empty_i = 1; wr_en_i = 1; wr_data_i = 8'h04; tick();
    chk("R2 reassert", status_o & 8'h04, 8'h04);
    tx_q_empty_i = 0; tick();
    chk("R2 ack clears", status_o & 8'h04, 8'h00);
    idle(); tick();

    // R3 plus R10 pop even when bit1 clear
    wr_en_i = 1; wr_data_i = 8'h02; tick();
    chk("R10 pop with bit1 clear", {7'd0, txdone_pop_o}, 8'h01);
    idle(); txdone_q_nonempty_i = 1; tick();
    chk("R3 set", status_o & 8'h02, 8'h02);
    wr_en_i = 1; wr_data_i = 8'h02; tick();
    chk("R3 reassert", status_o & 8'h02, 8'h02);
    idle(); txdone_q_nonempty_i = 0; wr_en_i = 1; wr_data_i = 8'h02; tick();
    chk("R3 ack clears", status_o & 8'h02, 8'h00);
    idle(); tick();
    chk("R10 single pulse", {7'd0, txdone_pop_o}, 8'h00);

    // R5 and R6 and R4 protection
    alloc_done_i = 1; rx_land_i = 1; tick();
    idle(); wr_en_i = 1; wr_data_i = 8'hFF; tick();
    chk("R4 bits 0 and 3 protected", status_o & 8'h09, 8'h09);
    idle(); alloc_req_i = 1; alloc_done_i = 1; tick();
    chk("R5 done wins", status_o & 8'h08, 8'h08);
    idle(); alloc_req_i = 1; tick();
    chk("R5 req clears", status_o & 8'h08, 8'h00);
    idle(); rx_pop_i = 1; rx_q_more_i = 1; tick();
    chk("R6 pop keeps", status_o & 8'h01, 8'h01);
    idle(); rx_pop_i = 1; rx_land_i = 1; tick();
    chk("R6 land wins", status_o & 8'h01, 8'h01);
    idle(); rx_pop_i = 1; tick();
    chk("R6 pop clears", status_o & 8'h01, 8'h00);

    // R7 set beats ack, R8 irq via mask
    idle(); rx_ovrn_i = 1; aux_evt_i = 2'b11; wr_en_i = 1; wr_data_i = 8'hD0; tick();
    chk("R7 set over ack", status_o & 8'hD0, 8'hD0);
    idle(); wr_en_i = 1; wr_addr_i = 1; wr_data_i = 8'h10; tick();
    chk("R8 irq masked in", {7'd0, irq_o}, 8'h01);
    idle(); wr_en_i = 1; wr_data_i = 8'h10; tick();
    chk("R7 ack clears", status_o & 8'h10, 8'h00);
    chk("R8 irq drops", {7'd0, irq_o}, 8'h00);
    idle(); tick();

    // constrained random
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] r;
      r = $urandom;
      idle();
      wr_en_i = (r[2:0] == 3'd0);
      wr_addr_i = r[3] & r[4];
      wr_data_i = r[15:8];
      tx_q_empty_i = r[16] & r[17];
      txdone_q_nonempty_i = r[18] & r[19];
      alloc_req_i = (r[22:20] == 3'd0);
      alloc_done_i = (r[25:23] == 3'd0);
      rx_ovrn_i = (r[28:26] == 3'd0);
      rx_land_i = (r[30:29] == 2'd0);
      rx_pop_i = r[31] & r[5];
      rx_q_more_i = r[6];
      aux_evt_i = (r[7] && r[1]) ? r[9:8] : 2'b00;
      tick();
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule